// File: doc/BRIEF.md
# Adaptive Frame-Pacing Vertical Total Controller

This block runs the vertical line counter for a display that must track an external video source whose frame rate cannot be matched exactly. The display is held slightly ahead of the source. Each time the source reports that a frame has been fully captured, the block samples the display's current line. If that line is past a threshold, the display is too far ahead, and the next frame is made one line longer. Otherwise the next frame is made one line shorter. Alternating between the two lengths keeps the display about nine tenths of a frame ahead of the source. That lead leaves around 1.6 ms to render each captured frame.

The chosen total drives two display timing counters, so both panels stay in lockstep. A new total takes effect only at the next frame boundary. A wide-mode input selects a second set of totals and threshold for a doubled line count. A line tick from the horizontal timing advances the counters. Horizontal timing and pixel generation are outside this block.

Top module: `frame_pacer`

## Requirements
- R1: After reset both line counts are 0, the active total is 414, and both frame-start outputs are low.
- R2: A line count advances by exactly one on a cycle with `line_tick` high, and holds its value on every cycle with `line_tick` low.
- R3: A tick while a line count equals `vtotal - 1` returns that count to 0. The matching frame-start output is then high for exactly one cycle, the cycle in which the count first reads 0.
- R4: When `capture_done` is high with `wide_mode` low, the pending total becomes 415 if display A's line count is greater than 373, and 414 otherwise. A count of exactly 373 selects 414.
- R5: The pending total becomes the active `vtotal` only on the tick that wraps the line count. `vtotal` never changes in the middle of a frame.
- R6: Both displays use the same active total and always show identical line counts and frame-start pulses.
- R7: When `capture_done` is high with `wide_mode` high, the pending total becomes 830 if the line count is greater than 746, and 829 otherwise.
- R8: If several capture events occur within one frame, the last one before the wrapping tick sets the total for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-cycle pulse at the end of each display line |
| capture_done | input | 1 | One-cycle pulse when the source finishes a frame |
| wide_mode | input | 1 | Selects the doubled totals and threshold |
| vcount_a | output | 10 | Current line of display A |
| vcount_b | output | 10 | Current line of display B |
| vtotal | output | 10 | Active vertical total shared by both displays |
| frame_start_a | output | 1 | Frame-start pulse of display A |
| frame_start_b | output | 1 | Frame-start pulse of display B |

## Verification
A wrong pending total stays hidden until the next frame boundary. After that boundary it shows on `vtotal`, and it shows again as a frame-start pulse that arrives one line early or one line late. That can be up to a full frame of ticks after the capture. The bench therefore follows every capture all the way through the next wrap. A counter fault or a loss of lockstep shows within one tick as a mismatched `vcount_a` and `vcount_b`. A premature total switch shows as a `vtotal` change on a cycle with no frame-start pulse.

// File: rtl/frame_pacer.sv
module frame_pacer #(
  parameter int CW       = 10,
  parameter int N_SHORT  = 414,
  parameter int N_LONG   = 415,
  parameter int N_THRESH = 373,
  parameter int W_SHORT  = 829,
  parameter int W_LONG   = 830,
  parameter int W_THRESH = 746
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_tick,
  input  logic          capture_done,
  input  logic          wide_mode,
  output logic [CW-1:0] vcount_a,
  output logic [CW-1:0] vcount_b,
  output logic [CW-1:0] vtotal,
  output logic          frame_start_a,
  output logic          frame_start_b
);
  localparam int NDISP = 2;

  logic [NDISP-1:0][CW-1:0] cnt;
  logic [NDISP-1:0]         fs;
  logic [CW-1:0]            next_total;
  logic [CW-1:0]            thresh, t_short, t_long, last_line;
  logic                     wrap_a;

  assign thresh    = wide_mode ? CW'(W_THRESH) : CW'(N_THRESH);
  assign t_short   = wide_mode ? CW'(W_SHORT)  : CW'(N_SHORT);
  assign t_long    = wide_mode ? CW'(W_LONG)   : CW'(N_LONG);
  assign last_line = vtotal - 1'b1;
  assign wrap_a    = line_tick && (cnt[0] == last_line);

  always_ff @(posedge clk) begin
    if (!rst_n)            next_total <= CW'(N_SHORT);
    else if (capture_done) next_total <= (cnt[0] > thresh) ? t_long : t_short;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      vtotal <= CW'(N_SHORT);
    else if (wrap_a) vtotal <= next_total;
  end

  for (genvar g = 0; g < NDISP; g++) begin : g_disp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[g] <= '0;
        fs[g]  <= 1'b0;
      end else begin
        fs[g] <= line_tick && (cnt[g] == last_line);
        if (line_tick) cnt[g] <= (cnt[g] == last_line) ? '0 : cnt[g] + 1'b1;
      end
    end
  end

  assign vcount_a      = cnt[0];
  assign vcount_b      = cnt[1];
  assign frame_start_a = fs[0];
  assign frame_start_b = fs[1];
endmodule

// File: rtl/frame_pacer_chk.sv
module frame_pacer_chk #(
  parameter int CW       = 10,
  parameter int N_SHORT  = 414,
  parameter int N_LONG   = 415,
  parameter int W_SHORT  = 829,
  parameter int W_LONG   = 830
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_tick,
  input logic [CW-1:0] vcount_a,
  input logic [CW-1:0] vcount_b,
  input logic [CW-1:0] vtotal,
  input logic          frame_start_a,
  input logic          frame_start_b
);
  AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (vcount_a == vcount_b) && (frame_start_a == frame_start_b)); // R6
  AST_COUNT_BELOW_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    vcount_a < vtotal); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !line_tick |=> $stable(vcount_a)); // R2
  AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_a |-> vcount_a == '0); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_a |=> !frame_start_a || vcount_a == '0); // R3
  AST_TOTAL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vtotal) |-> frame_start_a); // R5
  AST_TOTAL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    vtotal == CW'(N_SHORT) || vtotal == CW'(N_LONG) ||
    vtotal == CW'(W_SHORT) || vtotal == CW'(W_LONG)); // R4
endmodule

bind frame_pacer frame_pacer_chk #(
  .CW(CW), .N_SHORT(N_SHORT), .N_LONG(N_LONG), .W_SHORT(W_SHORT), .W_LONG(W_LONG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
  .vcount_a(vcount_a), .vcount_b(vcount_b), .vtotal(vtotal),
  .frame_start_a(frame_start_a), .frame_start_b(frame_start_b)
);

// File: tb/frame_pacer_tb.sv
`timescale 1ns/1ps
module frame_pacer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_tick = 1'b0;
  logic capture_done = 1'b0;
  logic wide_mode = 1'b0;
  logic [9:0] vcount_a, vcount_b, vtotal;
  logic frame_start_a, frame_start_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_cnt = 0, exp_total = 414, exp_pend = 414;

  always #2.5 clk = ~clk;

  frame_pacer u_dut (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .capture_done(capture_done),
    .wide_mode(wide_mode), .vcount_a(vcount_a), .vcount_b(vcount_b), .vtotal(vtotal),
    .frame_start_a(frame_start_a), .frame_start_b(frame_start_b)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic state_chk(input string req, input int fs_exp);
    chk(req, "vcount_a", vcount_a, exp_cnt);
    chk("R6", "vcount_b", vcount_b, exp_cnt);
    chk(req, "vtotal", vtotal, exp_total);
    chk(req, "frame_start_a", frame_start_a, fs_exp);
    chk("R6", "frame_start_b", frame_start_b, fs_exp);
  endtask

  task automatic tick(input string req);
    int fs_exp = 0;
    @(negedge clk) line_tick = 1'b1;
    @(negedge clk) line_tick = 1'b0;
    if (exp_cnt == exp_total - 1) begin
      exp_cnt = 0; exp_total = exp_pend; fs_exp = 1;
    end else exp_cnt++;
    state_chk(req, fs_exp);
    @(negedge clk);
    state_chk("R2", 0); // idle cycle: hold, pulse gone (R3)
  endtask

  task automatic run_to(input int target, input string req);
    while (exp_cnt != target) tick(req);
  endtask

  task automatic capture(input int wide);
    int thr = wide ? 746 : 373;
    @(negedge clk) begin wide_mode = wide[0]; capture_done = 1'b1; end
    @(negedge clk) capture_done = 1'b0;
    exp_pend = (exp_cnt > thr) ? (wide ? 830 : 415) : (wide ? 829 : 414);
  endtask

  task automatic t_reset;
    state_chk("R1", 0);
  endtask

  task automatic t_count;
    for (int i = 0; i < 10; i++) tick("R2");
    repeat (5) @(negedge clk);
    chk("R2", "hold vcount", vcount_a, 10);
  endtask

  task automatic t_wrap;
    run_to(413, "R2");
    tick("R3");
    chk("R3", "wrapped count", vcount_a, 0);
  endtask

  task automatic t_long;
    run_to(374, "R2");
    capture(0);
    chk("R5", "total mid-frame", vtotal, 414);
    run_to(413, "R5");
    tick("R4");
    chk("R4", "long total", vtotal, 415);
  endtask

  task automatic t_boundary;
    run_to(373, "R2");
    capture(0);
    run_to(414, "R5");
    chk("R4", "line 414 reached", vcount_a, 414);
    tick("R3");
    chk("R4", "boundary total", vtotal, 414);
  endtask

  task automatic t_latest;
    run_to(100, "R2");
    capture(0);
    run_to(380, "R2");
    capture(0);
    run_to(413, "R5");
    tick("R8");
    chk("R8", "last capture wins", vtotal, 415);
    run_to(380, "R2");
    capture(0);
    run_to(100 + 300, "R2");
    run_to(0, "R5");
    run_to(50, "R2");
    capture(0);
    run_to(0, "R8");
    chk("R8", "short restored", vtotal, 414);
  endtask

  task automatic t_wide;
    run_to(10, "R2");
    capture(1);
    run_to(0, "R7");
    chk("R7", "wide short", vtotal, 829);
    run_to(747, "R2");
    capture(1);
    run_to(0, "R7");
    chk("R7", "wide long", vtotal, 830);
    run_to(746, "R2");
    capture(1);
    run_to(0, "R7");
    chk("R7", "wide threshold", vtotal, 829);
    run_to(200, "R2");
    capture(0);
    run_to(0, "R4");
    chk("R4", "back to narrow", vtotal, 414);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_wrap();
    t_long();
    t_boundary();
    t_latest();
    t_wide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule